// File: doc/BRIEF.md
# Memory-to-Memory Three-Address Processor Core

A very small processor core with no data registers of its own. Every operand and every result is a location in one shared word memory. The core reaches that memory through a single synchronous port that makes one access per clock.

Each instruction carries three 15-bit addresses: two sources and one destination. The core fetches the instruction words, reads both operands into two internal holding registers, and computes a result. It writes the result back to the destination and then moves the program counter on.

The only state that software can see is a 15-bit program counter and two status flags, carry and zero. Control comes from an eight-step ring sequencer held in one-hot form, so every instruction costs exactly eight clocks. No call or return instruction exists. A routine returns by having the program overwrite a branch target inside its own code, so instruction words are always read fresh from memory.

Top module: `memop_core`

## Requirements
- R1: While rst_ni is low, pc, carry and zero are cleared, we_o is 0, and addr_o is 0. The first access after reset fetches address 0.
- R2: Every instruction takes 8 clocks. For an instruction at address p, with a one-cycle-latency memory, the accesses come in this order: p, p+1, source A, source B, p+2, p+3, destination, and then one idle step. The next instruction starts with a fetch at the updated pc.
- R3: Each instruction word holds a 15-bit address in bits 14:0. The opcode is {word0[15], word1[15], word2[15]}, and the fields are source A (word0), source B (word1) and destination (word2). The opcode values are: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift right through carry, 6 load immediate, 7 branch if zero.
- R4: Add writes A+B and sets carry to the carry out of bit 15. Subtract writes A-B and sets carry to 1 when a borrow occurs (A<B unsigned).
- R5: And, or and xor write the bitwise result and clear carry.
- R6: Shift right through carry writes {carry, A[15:1]} and sets carry to A[0].
- R7: Opcodes 0 to 5 set zero when the written result is 0 and clear it otherwise.
- R8: Load immediate is four words long. It writes word3 to the destination, leaves carry and zero unchanged, and advances pc by 4.
- R9: Branch if zero writes nothing and leaves the flags unchanged. It loads pc with the destination field when zero is set, and advances pc by 3 otherwise.
- R10: Instruction words are read from memory on every execution, so a write into a later instruction's field changes what that instruction does.
- R11: we_o is asserted only in the write step of an instruction, at most once per instruction, and never for a branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_o | output | 15 | Memory word address, one access per clock |
| wdata_o | output | 16 | Write data |
| rdata_i | input | 16 | Read data, valid one clock after its address |
| we_o | output | 1 | Write strobe for the current address |

## Verification
In the write step, the result write and the flag update share one clock edge. The program counter update comes in the very next step and reads the flags. So a branch that straight follows a flag-setting operation, or straight follows a load immediate that must keep those flags, is where a late or wrongly gated flag update would show. The test program puts a taken branch right after an add that wraps to zero. It puts a not-taken branch right after a shift whose carry-in came through a load immediate. A scoreboard judges the outcome from the exact order of addresses and values written. A skipped instruction that writes, or a branch to the wrong place, appears as an extra write, a missing write, or a write out of order.

// File: rtl/memop_pkg.sv
`timescale 1ns/1ps
package memop_pkg;
  localparam int unsigned DW  = 16;
  localparam int unsigned AW  = DW - 1;
  localparam int unsigned NST = 8;

  // one-hot step indices, in issue order
  localparam int unsigned S_F1   = 0;
  localparam int unsigned S_F2   = 1;
  localparam int unsigned S_RA   = 2;
  localparam int unsigned S_RB   = 3;
  localparam int unsigned S_F3   = 4;
  localparam int unsigned S_IMM  = 5;
  localparam int unsigned S_EXEC = 6;
  localparam int unsigned S_ADV  = 7;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_SHR = 3'd5,
    OP_LDI = 3'd6,
    OP_BRZ = 3'd7
  } op_e;
endpackage

// File: rtl/memop_seq.sv
`timescale 1ns/1ps
module memop_seq #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [N-1:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= N'(1);
    else         state_o <= {state_o[N-2:0], state_o[N-1]};
  end
endmodule

// File: rtl/memop_alu.sv
`timescale 1ns/1ps
module memop_alu
  import memop_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         z_o
);
  logic [W:0] ext;

  always_comb begin
    ext   = '0;
    res_o = '0;
    c_o   = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        ext   = {1'b0, a_i} + {1'b0, b_i};
        res_o = ext[W-1:0];
        c_o   = ext[W];
      end
      OP_SUB: begin
        ext   = {1'b0, a_i} - {1'b0, b_i};
        res_o = ext[W-1:0];
        c_o   = ext[W];          // borrow
      end
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_SHR: begin
        res_o = {c_i, a_i[W-1:1]};
        c_o   = a_i[0];
      end
      default: begin
        res_o = a_i;
        c_o   = c_i;
      end
    endcase
    z_o = (res_o == '0);
  end
endmodule

// File: rtl/memop_pc.sv
`timescale 1ns/1ps
module memop_pc #(
  parameter int unsigned AW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          taken_i,
  input  logic          long_i,
  input  logic [AW-1:0] tgt_i,
  output logic [AW-1:0] pc_o
);
  localparam logic [AW-1:0] STEP_SHORT = AW'(3);
  localparam logic [AW-1:0] STEP_LONG  = AW'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_o <= '0;
    else if (adv_i) begin
      if (taken_i)    pc_o <= tgt_i;
      else if (long_i) pc_o <= pc_o + STEP_LONG;
      else            pc_o <= pc_o + STEP_SHORT;
    end
  end
endmodule

// File: rtl/memop_core.sv
`timescale 1ns/1ps
module memop_core
  import memop_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic [DW-1:0] rdata_i,
  output logic          we_o
);
  logic [NST-1:0] state;
  logic [AW-1:0]  pc_q;
  logic [AW-1:0]  a_addr_q, b_addr_q, dst_q;
  logic [DW-1:0]  tmp_a_q, tmp_b_q;
  logic [2:0]     op_bits;
  logic           op2_q, op1_q, op0_q;
  logic           c_q, z_q;
  op_e            op;
  logic [DW-1:0]  alu_res;
  logic           alu_c, alu_z;
  logic           alu_op;

  assign op_bits = {op2_q, op1_q, op0_q};
  assign op      = op_e'(op_bits);
  assign alu_op  = (op != OP_LDI) && (op != OP_BRZ);

  memop_seq #(.N(NST)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_o(state)
  );

  memop_alu #(.W(DW)) u_alu (
    .op_i (op),
    .a_i  (tmp_a_q),
    .b_i  (tmp_b_q),
    .c_i  (c_q),
    .res_o(alu_res),
    .c_o  (alu_c),
    .z_o  (alu_z)
  );

  memop_pc #(.AW(AW)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (state[S_ADV]),
    .taken_i((op == OP_BRZ) && z_q),
    .long_i (op == OP_LDI),
    .tgt_i  (dst_q),
    .pc_o   (pc_q)
  );

  // read data arrives one step after its address was issued
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_addr_q <= '0;
      b_addr_q <= '0;
      dst_q    <= '0;
      tmp_a_q  <= '0;
      tmp_b_q  <= '0;
      op2_q    <= 1'b0;
      op1_q    <= 1'b0;
      op0_q    <= 1'b0;
      c_q      <= 1'b0;
      z_q      <= 1'b0;
    end else begin
      if (state[S_F2]) begin
        a_addr_q <= rdata_i[AW-1:0];
        op2_q    <= rdata_i[DW-1];
      end
      if (state[S_RA]) begin
        b_addr_q <= rdata_i[AW-1:0];
        op1_q    <= rdata_i[DW-1];
      end
      if (state[S_RB])  tmp_a_q <= rdata_i;
      if (state[S_F3])  tmp_b_q <= rdata_i;
      if (state[S_IMM]) begin
        dst_q <= rdata_i[AW-1:0];
        op0_q <= rdata_i[DW-1];
      end
      if (state[S_EXEC] && alu_op) begin
        c_q <= alu_c;
        z_q <= alu_z;
      end
    end
  end

  always_comb begin
    addr_o = pc_q;
    if (state[S_F2])   addr_o = pc_q + AW'(1);
    if (state[S_RA])   addr_o = a_addr_q;
    if (state[S_RB])   addr_o = b_addr_q;
    if (state[S_F3])   addr_o = pc_q + AW'(2);
    if (state[S_IMM])  addr_o = pc_q + AW'(3);
    if (state[S_EXEC]) addr_o = dst_q;
  end

  assign we_o    = state[S_EXEC] && (op != OP_BRZ);
  assign wdata_o = (op == OP_LDI) ? rdata_i : alu_res;
endmodule

// File: rtl/memop_core_chk.sv
`timescale 1ns/1ps
module memop_core_chk
  import memop_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic [AW-1:0]  addr_o,
  input logic           we_o,
  input logic [NST-1:0] state_i,
  input logic [AW-1:0]  pc_i,
  input logic [AW-1:0]  dst_i,
  input logic [2:0]     op_i,
  input logic           c_i,
  input logic           z_i
);
  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_i) == 1);

  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i[S_ADV] |=> state_i[S_F1]);

  assert_fetch_pc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i[S_F1] |-> addr_o == pc_i);

  assert_pc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !state_i[S_ADV] |=> $stable(pc_i));

  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i[S_ADV] && op_i != OP_BRZ && op_i != OP_LDI) |=> pc_i == AW'($past(pc_i) + AW'(3)));

  assert_we_exec_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> state_i[S_EXEC]);

  assert_flag_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!state_i[S_EXEC] || op_i == OP_LDI || op_i == OP_BRZ) |=> $stable({c_i, z_i}));

  assert_taken_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i[S_ADV] && op_i == OP_BRZ && z_i) |=> pc_i == $past(dst_i));
endmodule

bind memop_core memop_core_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_o (addr_o),
  .we_o   (we_o),
  .state_i(state),
  .pc_i   (pc_q),
  .dst_i  (dst_q),
  .op_i   (op_bits),
  .c_i    (c_q),
  .z_i    (z_q)
);

// File: tb/memop_core_tb_top.sv
`timescale 1ns/1ps
module memop_core_tb_top;
  import memop_pkg::*;

  localparam int RAM_AW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          we;
  logic [DW-1:0] ram [2**RAM_AW];

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [AW-1:0] exp_addr_q [$];
  logic [DW-1:0] exp_data_q [$];
  string         exp_tag_q  [$];

  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) begin
    if (we) ram[addr[RAM_AW-1:0]] <= wdata;
    rdata <= ram[addr[RAM_AW-1:0]];
  end

  memop_core dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .addr_o (addr),
    .wdata_o(wdata),
    .rdata_i(rdata),
    .we_o   (we)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put_ins(input int pc, input op_e op, input int a, input int b, input int d);
    ram[pc]   = {op[2], a[AW-1:0]};
    ram[pc+1] = {op[1], b[AW-1:0]};
    ram[pc+2] = {op[0], d[AW-1:0]};
  endtask

  task automatic expect_wr(input int a, input int d, input string req);
    exp_addr_q.push_back(a[AW-1:0]);
    exp_data_q.push_back(d[DW-1:0]);
    exp_tag_q.push_back(req);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && we && !done) begin
      if (exp_addr_q.size() == 0) begin
        check(1'b0, "R11", "unexpected write addr", 32'(addr), 32'hffff_ffff);
      end else begin
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        string         tg;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        tg = exp_tag_q.pop_front();
        check(addr == ea, tg, "write addr", 32'(addr), 32'(ea));
        check(wdata == ed, tg, "write data", 32'(wdata), 32'(ed));
      end
    end
  end

  initial begin
    #4000000;
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int exp_seq [9];
    int cyc;
    exp_seq = '{0, 1, 'h80, 'h81, 2, 3, 'h90, -1, 3};

    for (int i = 0; i < 2**RAM_AW; i++) ram[i] = '0;
    ram['h80] = 16'h1234;
    ram['h81] = 16'hF0F0;
    ram['h82] = 16'hFFFF;
    ram['h83] = 16'h0001;
    ram['h84] = 16'h0000;
    ram['h9E] = 16'h5555;
    ram['h9F] = 16'h5555;

    put_ins(0,  OP_ADD, 'h80, 'h81, 'h90);
    put_ins(3,  OP_SHR, 'h83, 'h84, 'h91);
    put_ins(6,  OP_SHR, 'h84, 'h84, 'h92);
    put_ins(9,  OP_SHR, 'h84, 'h84, 'h93);
    put_ins(12, OP_SUB, 'h83, 'h82, 'h94);
    put_ins(15, OP_SHR, 'h84, 'h84, 'h95);
    put_ins(18, OP_AND, 'h80, 'h81, 'h96);
    put_ins(21, OP_OR,  'h80, 'h81, 'h97);
    put_ins(24, OP_XOR, 'h80, 'h81, 'h98);
    put_ins(27, OP_ADD, 'h82, 'h83, 'h99);
    put_ins(30, OP_BRZ, 'h84, 'h84, 36);
    put_ins(33, OP_ADD, 'h80, 'h80, 'h9F);   // skipped
    put_ins(36, OP_LDI, 'h84, 'h84, 'h9B);
    ram[39] = 16'hBEEF;
    put_ins(40, OP_SHR, 'h84, 'h84, 'h9C);
    put_ins(43, OP_BRZ, 'h84, 'h84, 0);
    put_ins(46, OP_LDI, 'h84, 'h84, 52);     // patches dest of next
    ram[49] = 16'h009D;
    put_ins(50, OP_ADD, 'h80, 'h80, 'h9E);
    put_ins(53, OP_XOR, 'h84, 'h84, 'hA0);
    put_ins(56, OP_BRZ, 'h84, 'h84, 56);

    expect_wr('h90, 'h0324, "R4 R3");
    expect_wr('h91, 'h8000, "R6 R3");
    expect_wr('h92, 'h8000, "R6");
    expect_wr('h93, 'h0000, "R6");
    expect_wr('h94, 'h0002, "R4");
    expect_wr('h95, 'h8000, "R4");
    expect_wr('h96, 'h1030, "R5");
    expect_wr('h97, 'hF2F4, "R5");
    expect_wr('h98, 'hE2C4, "R5");
    expect_wr('h99, 'h0000, "R7");
    expect_wr('h9B, 'hBEEF, "R8");
    expect_wr('h9C, 'h8000, "R8");
    expect_wr(52,   'h009D, "R10");
    expect_wr('h9D, 'h2468, "R10");
    expect_wr('hA0, 'h0000, "R7");

    repeat (3) @(negedge clk);
    check(addr == '0, "R1", "addr in reset", 32'(addr), 0);
    check(we == 1'b0, "R1", "we in reset", 32'(we), 0);

    rst_ni = 1'b1;
    #1;
    for (int k = 0; k < 9; k++) begin
      if (k > 0) begin
        @(negedge clk);
        #1;
      end
      if (exp_seq[k] >= 0)
        check(addr == AW'(exp_seq[k]), "R2", "access order", 32'(addr), 32'(exp_seq[k]));
      check(we == (k == 6), "R11", "write strobe step", 32'(we), 32'(k == 6));
    end

    cyc = 0;
    while (exp_addr_q.size() != 0 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 3000) check(1'b0, "WDOG", "pending writes", 32'(exp_addr_q.size()), 0);

    repeat (64) @(negedge clk);   // idle loop must not write (R9 R11)
    done = 1'b1;

    check(ram['h9F] == 16'h5555, "R9", "skipped instr dest", 32'(ram['h9F]), 32'h5555);
    check(ram['h9E] == 16'h5555, "R10", "old dest untouched", 32'(ram['h9E]), 32'h5555);
    check(ram[52] == 16'h009D, "R10", "patched word", 32'(ram[52]), 32'h009D);
    check(ram['h9B] == 16'hBEEF, "R8", "immediate stored", 32'(ram['h9B]), 32'hBEEF);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule